// File: doc/BRIEF.md
# Vector Lane Equal/Not-Equal Finder

This unit takes two 128-bit operands and splits each of them into lanes of 8, 16 or 32 bits. Each lane of operand A is compared only with the lane of operand B at the same position. In equal mode the unit looks for the first lane pair that holds the same value. In not-equal mode it looks for the first lane pair that differs, and it also reports whether A or B is smaller there, treating both as unsigned.

An optional terminator search looks for the first all-zero lane in operand A. When it is enabled, the reported position is whichever comes first: that zero lane or the qualifying lane. The position is given as a byte offset. Byte 0 is the most significant byte, bits 127:120. A value of 16 means nothing was found. A two-bit condition code summarises the outcome.

A caller presents the operands and the mode with a one-cycle `start`. The registered result and code appear on the next cycle, with a one-cycle `valid`.

Top module: `vec_lane_find`

## Requirements
- R1: While reset is asserted and after its release, `valid` is low and both `result` and `cc` read zero until the first `start`.
- R2: A `start` sampled at a clock edge makes `valid` high for exactly the following cycle. Without `start`, `valid` stays low.
- R3: With `mode_ne`=0, the index is the byte offset of the first lane where the A lane equals the B lane at the same position. Equality between lanes at different positions never counts.
- R4: With `mode_ne`=1, the index is the byte offset of the first lane where the A lane differs from the B lane.
- R5: `esize` selects the lane width: 0 gives 8 bits, 1 gives 16 bits, 2 gives 32 bits, and 3 behaves as 32 bits. A lane matches only if all of its bytes match, and the index is always a multiple of the lane width in bytes.
- R6: When no lane qualifies and the terminator search finds nothing, the index is 16.
- R7: With `zero_en`=1, the index is the smaller of two offsets: the first qualifying lane, and the first lane of A that is entirely zero.
- R8: The index is an unsigned value in `result[127:64]`, and `result[63:0]` is zero.
- R9: In equal mode, `cc` is set as follows:
  - 3 when there is neither a match nor a zero lane.
  - 1 when there is a match but no zero lane.
  - 2 when the match lies strictly before the zero lane.
  - 0 in every other case.
- R10: In not-equal mode, `cc` is set as follows:
  - 3 when there is neither a mismatch nor a zero lane.
  - 0 when the zero lane lies strictly before the first mismatch.
  - 1 when, at the first mismatch, the A lane is unsigned-less than the B lane.
  - 2 in every other case.
- R11: With `zero_en`=0, all-zero lanes in A have no effect on the index or on `cc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Capture the operands and mode on this edge |
| mode_ne | input | 1 | 0 = find first equal lane, 1 = find first differing lane |
| zero_en | input | 1 | Enable the search for an all-zero lane in A |
| esize | input | 2 | Lane width select: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits |
| op_a | input | 128 | Operand A, byte 0 in bits 127:120 |
| op_b | input | 128 | Operand B, same layout as A |
| valid | output | 1 | One-cycle pulse marking a new result |
| result | output | 128 | Index in bits 127:64, zero in bits 63:0 |
| cc | output | 2 | Condition code for the last search |

## Verification
A wrong lane-width selection or a wrong priority order between the match and the zero lane shows up in the same cycle as `valid`. It appears as a misaligned or premature index, or as a code that disagrees with where the index landed. A wrong less-than pick at the mismatch lane shows only in not-equal mode, as a swapped code 1 or 2 with a correct index. For that reason, cases with A larger and with A smaller are both driven. The lane-wise-only rule and the disabled-terminator rule are checked with operands that would match if either rule were broken.

// File: rtl/vlf_pkg.sv
// Package: shared sizes and encodings for the lane finder.
// Assumes a 128-bit vector and three lane widths (1, 2, 4 bytes).
package vlf_pkg;
    localparam int VEC_BYTES = 16;
    localparam int VEC_BITS  = 8 * VEC_BYTES;
    localparam int IDX_W     = $clog2(VEC_BYTES) + 1;
    localparam int NUM_SIZES = 3;

    typedef enum logic [1:0] {
        CC_ZERO_FIRST = 2'd0,
        CC_ONE        = 2'd1,
        CC_TWO        = 2'd2,
        CC_NONE       = 2'd3
    } cc_e;
endpackage

// File: rtl/vlf_lane_cmp.sv
// Module: compares A and B lane by lane for one fixed lane width.
// Marks are placed on the first byte of each lane; other bits are zero.
// Assumes VEC_BYTES is a multiple of LANE_BYTES and LANE_BYTES <= 4.
module vlf_lane_cmp #(
    parameter int LANE_BYTES = 1,
    parameter int VEC_BYTES  = 16
) (
    input  logic [8*VEC_BYTES-1:0] a_i,
    input  logic [8*VEC_BYTES-1:0] b_i,
    output logic [VEC_BYTES-1:0]   eq_o,
    output logic [VEC_BYTES-1:0]   ne_o,
    output logic [VEC_BYTES-1:0]   zero_o,
    output logic [VEC_BYTES-1:0]   lt_o
);
    localparam int LANES = VEC_BYTES / LANE_BYTES;
    localparam int LW    = 8 * LANE_BYTES;
    localparam int TOP   = 8 * VEC_BYTES - 1;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int HI = TOP - k * LW;
        localparam int BP = k * LANE_BYTES;
        logic [LW-1:0] la, lb;
        // Slice this lane out of both operands.
        assign la = a_i[HI -: LW];
        assign lb = b_i[HI -: LW];
        // Flags at the lane's first byte.
        assign eq_o[BP]   = (la == lb);
        assign ne_o[BP]   = (la != lb);
        assign zero_o[BP] = (la == '0);
        assign lt_o[BP]   = (la < lb);
        for (genvar j = 1; j < LANE_BYTES; j++) begin : g_pad
            // Non-leading bytes never qualify.
            assign eq_o[BP+j]   = 1'b0;
            assign ne_o[BP+j]   = 1'b0;
            assign zero_o[BP+j] = 1'b0;
            assign lt_o[BP+j]   = 1'b0;
        end
    end
endmodule

// File: rtl/vlf_first.sv
// Module: priority encoder returning the lowest set position, or N if none.
// Assumes IW can hold the value N.
module vlf_first #(
    parameter int N  = 16,
    parameter int IW = 5
) (
    input  logic [N-1:0]  hits_i,
    output logic [IW-1:0] idx_o
);
    // Scan from the top so the lowest hit wins.
    always_comb begin
        idx_o = IW'(N);
        for (int i = N - 1; i >= 0; i--) begin
            if (hits_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/vec_lane_find.sv
// Module: top of the lane equal/not-equal finder.
// Builds one comparator bank per lane width, selects one with esize,
// encodes the first qualifying lane and the first zero lane,
// and registers the index and condition code one cycle after start.
// Assumes the inputs are stable at the edge where start is sampled.
module vec_lane_find
    import vlf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                mode_ne,
    input  logic                zero_en,
    input  logic [1:0]          esize,
    input  logic [VEC_BITS-1:0] op_a,
    input  logic [VEC_BITS-1:0] op_b,
    output logic                valid,
    output logic [VEC_BITS-1:0] result,
    output logic [1:0]          cc
);
    localparam int HALF = VEC_BITS / 2;

    logic [VEC_BYTES-1:0] eq_m   [NUM_SIZES];
    logic [VEC_BYTES-1:0] ne_m   [NUM_SIZES];
    logic [VEC_BYTES-1:0] zero_m [NUM_SIZES];
    logic [VEC_BYTES-1:0] lt_m   [NUM_SIZES];

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        vlf_lane_cmp #(.LANE_BYTES(1 << g), .VEC_BYTES(VEC_BYTES)) u_cmp (
            .a_i    (op_a),
            .b_i    (op_b),
            .eq_o   (eq_m[g]),
            .ne_o   (ne_m[g]),
            .zero_o (zero_m[g]),
            .lt_o   (lt_m[g])
        );
    end

    logic [1:0]           sz_sel;
    logic [VEC_BYTES-1:0] hit_v, zhit_v, lt_v;
    logic [IDX_W-1:0]     idx_hit, idx_zero, idx_pick;
    logic                 lt_at_hit;
    logic [1:0]           cc_next;

    // Map the size code to a bank; code 3 shares the 32-bit bank.
    always_comb begin
        case (esize)
            2'd0:    sz_sel = 2'd0;
            2'd1:    sz_sel = 2'd1;
            default: sz_sel = 2'd2;
        endcase
    end

    // Pick the qualifying marks for the mode and gate the zero marks.
    always_comb begin
        hit_v  = mode_ne ? ne_m[sz_sel] : eq_m[sz_sel];
        zhit_v = zero_en ? zero_m[sz_sel] : '0;
        lt_v   = lt_m[sz_sel];
    end

    vlf_first #(.N(VEC_BYTES), .IW(IDX_W)) u_first_hit (
        .hits_i (hit_v),
        .idx_o  (idx_hit)
    );

    vlf_first #(.N(VEC_BYTES), .IW(IDX_W)) u_first_zero (
        .hits_i (zhit_v),
        .idx_o  (idx_zero)
    );

    // Less-than flag at the first mismatching lane and the merged index.
    always_comb begin
        lt_at_hit = (idx_hit < IDX_W'(VEC_BYTES)) ? lt_v[idx_hit[IDX_W-2:0]] : 1'b0;
        idx_pick  = (idx_zero < idx_hit) ? idx_zero : idx_hit;
    end

    // Condition code from the relative position of hit and zero.
    always_comb begin
        if (idx_hit == IDX_W'(VEC_BYTES) && idx_zero == IDX_W'(VEC_BYTES))
            cc_next = CC_NONE;
        else if (mode_ne)
            cc_next = (idx_zero < idx_hit) ? CC_ZERO_FIRST : (lt_at_hit ? CC_ONE : CC_TWO);
        else if (idx_zero == IDX_W'(VEC_BYTES))
            cc_next = CC_ONE;
        else if (idx_hit < idx_zero)
            cc_next = CC_TWO;
        else
            cc_next = CC_ZERO_FIRST;
    end

    // Output register stage with a single-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            result <= '0;
            cc     <= 2'd0;
        end else begin
            valid <= start;
            if (start) begin
                result <= {HALF'(idx_pick), HALF'(0)};
                cc     <= cc_next;
            end
        end
    end

    // valid only ever follows a sampled start.
    assert_valid_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(start));

    // The lower doubleword carries no data.
    assert_low_dword_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> result[HALF-1:0] == '0);

    // The index never exceeds the no-hit value.
    assert_index_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> result[VEC_BITS-1:HALF] <= HALF'(VEC_BYTES));

    // Code 3 appears exactly when nothing was found (R10 in not-equal mode).
    assert_cc_none_matches_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((cc == 2'd3) == (result[VEC_BITS-1:HALF] == HALF'(VEC_BYTES))));

    // Wider lanes give aligned offsets.
    assert_index_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && $past(esize) != 2'd0) |-> !result[HALF]);
endmodule

// File: tb/vec_lane_find_bench.sv
module vec_lane_find_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         mode_ne = 1'b0;
    logic         zero_en = 1'b0;
    logic [1:0]   esize = 2'd0;
    logic [127:0] op_a = '0;
    logic [127:0] op_b = '0;
    logic         valid;
    logic [127:0] result;
    logic [1:0]   cc;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    vec_lane_find u_vec_lane_find (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_ne(mode_ne),
        .zero_en(zero_en), .esize(esize), .op_a(op_a), .op_b(op_b),
        .valid(valid), .result(result), .cc(cc)
    );

    function automatic logic [31:0] lane_val(logic [127:0] v, int off, int lb);
        logic [31:0] r = '0;
        for (int j = 0; j < lb; j++) r = (r << 8) | 32'(v[127 - 8*(off + j) -: 8]);
        return r;
    endfunction

    function automatic void model(logic [127:0] a, logic [127:0] b, logic ne, logic zen,
                                  logic [1:0] es, output int idx, output logic [1:0] c);
        int lb = (es == 2'd0) ? 1 : (es == 2'd1) ? 2 : 4;
        int fq = 16;
        int fz = 16;
        logic lt = 1'b0;
        for (int off = 0; off < 16; off += lb) begin
            logic [31:0] av = lane_val(a, off, lb);
            logic [31:0] bv = lane_val(b, off, lb);
            if (fq == 16 && (ne ? (av != bv) : (av == bv))) begin
                fq = off;
                lt = av < bv;
            end
            if (zen && fz == 16 && av == 0) fz = off;
        end
        idx = (fz < fq) ? fz : fq;
        if (fq == 16 && fz == 16) c = 2'd3;
        else if (ne) c = (fz < fq) ? 2'd0 : (lt ? 2'd1 : 2'd2);
        else if (fz == 16) c = 2'd1;
        else if (fq < fz) c = 2'd2;
        else c = 2'd0;
    endfunction

    function automatic logic [127:0] put_byte(logic [127:0] v, int p, logic [7:0] x);
        logic [127:0] r = v;
        r[127 - 8*p -: 8] = x;
        return r;
    endfunction

    task automatic check(string req, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_case(string req, logic [127:0] a, logic [127:0] b,
                            logic ne, logic zen, logic [1:0] es);
        int ei;
        logic [1:0] ec;
        model(a, b, ne, zen, es, ei, ec);
        @(negedge clk);
        op_a = a; op_b = b; mode_ne = ne; zero_en = zen; esize = es; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2", {req, " valid"}, 128'(valid), 128'(1));
        check(req, "result (R8 layout)", result, {64'(ei), 64'd0});
        check(req, "cc", 128'(cc), 128'(ec));
        @(negedge clk);
        check("R2", {req, " valid drop"}, 128'(valid), 128'(0));
    endtask

    // A with no zero bytes; B all bytes differ from A.
    localparam logic [127:0] BASE = 128'h1122_3344_5566_7788_99AA_BBCC_DDEE_F0F1;

    task automatic t_reset_R1();
        repeat (3) @(negedge clk);
        check("R1", "valid in reset", 128'(valid), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1", "valid after reset", 128'(valid), 128'(0));
        check("R1", "result after reset", result, 128'd0);
        check("R1", "cc after reset", 128'(cc), 128'(0));
    endtask

    task automatic t_equal_R3();
        logic [127:0] b = put_byte(~BASE, 5, BASE[127-40 -: 8]);
        run_case("R3", BASE, b, 1'b0, 1'b0, 2'd0);           // idx 5, cc1
        // B holds A's lanes rotated by one byte: cross-lane only.
        run_case("R3", BASE, {BASE[119:0], BASE[127:120]}, 1'b0, 1'b0, 2'd0);
    endtask

    task automatic t_notequal_R4();
        logic [127:0] b = put_byte(BASE, 7, 8'hFF);           // A smaller at halfword 6
        run_case("R4", BASE, b, 1'b1, 1'b0, 2'd1);
        run_case("R10", BASE, put_byte(BASE, 9, 8'h00), 1'b1, 1'b0, 2'd2); // A larger, idx 8
    endtask

    task automatic t_size_R5();
        // Bytes 4 agree but byte 5 differs: 8-bit hits, 16-bit must not hit there.
        logic [127:0] b = put_byte(~BASE, 4, BASE[127-32 -: 8]);
        run_case("R5", BASE, b, 1'b0, 1'b0, 2'd0);
        run_case("R5", BASE, b, 1'b0, 1'b0, 2'd1);
        run_case("R5", BASE, put_byte(BASE, 13, 8'h00), 1'b1, 1'b0, 2'd3); // as 32-bit, idx 12
    endtask

    task automatic t_none_R6();
        run_case("R6", BASE, ~BASE, 1'b0, 1'b0, 2'd2);
        run_case("R6", BASE, BASE, 1'b1, 1'b1, 2'd0);
    endtask

    task automatic t_zero_R7();
        logic [127:0] a = put_byte(BASE, 2, 8'h00);
        logic [127:0] b = put_byte(~a, 9, a[127-72 -: 8]);
        run_case("R7", a, b, 1'b0, 1'b1, 2'd0);              // idx 2, cc0
    endtask

    task automatic t_eq_cc_R9();
        logic [127:0] a = put_byte(BASE, 10, 8'h00);
        logic [127:0] b = put_byte(~a, 3, a[127-24 -: 8]);
        run_case("R9", a, b, 1'b0, 1'b1, 2'd0);              // match before zero: cc2
        run_case("R9", BASE, put_byte(~BASE, 6, BASE[127-48 -: 8]), 1'b0, 1'b1, 2'd0); // cc1
        a = put_byte(BASE, 4, 8'h00);
        b = put_byte(~BASE, 4, 8'h00);                       // tie at 4: cc0
        run_case("R9", a, b, 1'b0, 1'b1, 2'd0);
    endtask

    task automatic t_ne_cc_R10();
        logic [127:0] a = put_byte(BASE, 4, 8'h00);
        run_case("R10", a, put_byte(a, 12, 8'h01), 1'b1, 1'b1, 2'd0);   // zero first: cc0
        a = {BASE[127:32], 32'd0};
        run_case("R10", a, put_byte(a, 13, 8'h05), 1'b1, 1'b1, 2'd2);   // tie at 12: A<B cc1
        run_case("R10", a, a, 1'b1, 1'b1, 2'd2);                         // no mismatch, zero: cc0
    endtask

    task automatic t_zero_ignored_R11();
        logic [127:0] a = put_byte(BASE, 1, 8'h00);
        run_case("R11", a, put_byte(~a, 7, a[127-56 -: 8]), 1'b0, 1'b0, 2'd0); // idx 7 cc1
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset_R1();
        t_equal_R3();
        t_notequal_R4();
        t_size_R5();
        t_none_R6();
        t_zero_R7();
        t_eq_cc_R9();
        t_ne_cc_R10();
        t_zero_ignored_R11();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule